// File: doc/BRIEF.md
# Complementary Dead-Band Generator

The block turns a single PWM waveform into a pair of active-high complementary gate-drive signals. Output A follows the PWM input but its rising edge is held back by a programmable number of clocks; output B is the inverse of the input, and its rising edge is held back by a second programmable count. The result is a guard interval at each switching transition, during which neither output is high. This gives the two power switches of a half-bridge time to turn off before the other one turns on.

Both delays are 10-bit counts of the timebase clock and are set independently. A typical setting is 20 counts, which is about one microsecond at a 20 MHz timebase. A bridge built from several legs uses one instance per leg, all with the same settings. When the enable input is low, the delays are bypassed: A copies the input and B copies its inverse.

All outputs are registered, so a zero delay still costs one clock. A new edge on the input restarts the matching counter. Any delay still pending for the opposite edge is dropped.

Top module: `dbg_deadband`

## Requirements
- R1: While rst_n is low at a clock edge, both out_a and out_b are low after that edge and both delay counters are cleared. After release with pwm_in low, out_b rises exactly fall_dly clock edges after the first edge (numbered 0) that samples rst_n high.
- R2: With enable high, out_a rises rise_dly edges after edge 0, where edge 0 is the first edge that samples pwm_in high. It falls after the first edge that samples pwm_in low.
- R3: With enable high, out_b falls after the first edge that samples pwm_in high. It rises fall_dly edges after edge 0, where edge 0 is the first edge that samples pwm_in low.
- R4: A delay setting of 0 makes the matching output change after the same edge that samples the input change.
- R5: A high pulse lasting no more than rise_dly clocks produces no pulse on out_a. A low interval lasting no more than fall_dly clocks produces no pulse on out_b.
- R6: An input edge that arrives while a delay is pending cancels that delay. The next delay is counted in full from the newer edge.
- R7: out_a and out_b are never high in the same cycle.
- R8: With enable low, out_a equals pwm_in as sampled at the previous edge and out_b is its inverse. The delay settings have no effect.
- R9: The full 10-bit range is honoured. A setting of 1023 delays the edge by 1023 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | 1 = apply dead band, 0 = direct complementary bypass |
| pwm_in | input | 1 | Raw PWM waveform |
| rise_dly | input | 10 | Clocks added to the rising edge of out_a |
| fall_dly | input | 10 | Clocks added to the rising edge of out_b (input falling edge) |
| out_a | output | 1 | Rising-edge-delayed copy of pwm_in |
| out_b | output | 1 | Inverted, falling-edge-delayed copy of pwm_in |

## Verification
The bound checker tests four things on every cycle: the outputs never overlap, reset forces both outputs low, each output drops on the edge after its input level goes away, and bypass mode tracks the input with one cycle of latency. It also checks that a zero delay reacts in the next cycle. The exact length of each delay, the suppression of short pulses, the restart of a counter by a new edge, and the extreme 1023 setting depend on counted windows. Only the bench's scenarios can show these, by comparing the output pattern cycle by cycle against the expected timing.

// File: rtl/dbg_pkg.sv
// Shared definitions for the dead-band generator.
// Assumes: all logic runs in the single timebase clock domain.
package dbg_pkg;
    localparam int DLY_W_DEFAULT = 10;
    localparam int NUM_PATHS     = 2;   // path 0 drives out_a, path 1 drives out_b

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/dbg_edge_detect.sv
// Registers a level and reports its rising and falling transitions.
// Assumes: sig is synchronous to clk; the previous level resets to low.
module dbg_edge_detect
    import dbg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sig,
    output edge_t ev
);
    logic prev_q;

    // Keep the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    // Compare the current level with the stored one.
    always_comb begin
        ev.rise = sig & ~prev_q;
        ev.fall = ~sig & prev_q;
    end
endmodule

// File: rtl/dbg_delay_unit.sv
// Delays the rising edge of a level by a programmable clock count and
// passes the falling edge through after one clock.
// Assumes: dly is sampled on the edge that detects a rising transition;
// a falling transition cancels any pending count.
module dbg_delay_unit
    import dbg_pkg::*;
#(
    parameter int DLY_W = DLY_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sig,
    input  logic [DLY_W-1:0] dly,
    output logic             out
);
    localparam logic [DLY_W-1:0] CNT_ZERO = '0;
    localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);

    edge_t            ev;
    logic [DLY_W-1:0] cnt_q;
    logic             out_q;

    dbg_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (sig),
        .ev    (ev)
    );

    // Count down after each rising transition and raise the output at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
            out_q <= 1'b0;
        end else if (!en) begin
            cnt_q <= CNT_ZERO;
            out_q <= sig;
        end else if (ev.rise) begin
            out_q <= (dly == CNT_ZERO);
            cnt_q <= dly;
        end else if (ev.fall) begin
            cnt_q <= CNT_ZERO;
            out_q <= 1'b0;
        end else if (cnt_q != CNT_ZERO) begin
            cnt_q <= cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) out_q <= 1'b1;
        end
    end

    assign out = out_q;
endmodule

// File: rtl/dbg_deadband.sv
// Complementary dead-band generator: out_a is the input with a delayed
// rising edge; out_b is the inverted input with a delayed rising edge
// (the input's falling edge, delayed).
// Assumes: one PWM input; active-high complementary polarity only.
module dbg_deadband
    import dbg_pkg::*;
#(
    parameter int DLY_W = DLY_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pwm_in,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             out_a,
    output logic             out_b
);
    logic [NUM_PATHS-1:0] path_in;
    logic [NUM_PATHS-1:0] path_out;
    logic [DLY_W-1:0]     path_dly [NUM_PATHS];

    // Route the true input to path 0 and the inverted input to path 1.
    always_comb begin
        path_in[0]  = pwm_in;
        path_in[1]  = ~pwm_in;
        path_dly[0] = rise_dly;
        path_dly[1] = fall_dly;
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        dbg_delay_unit #(.DLY_W(DLY_W)) u_delay (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (enable),
            .sig   (path_in[p]),
            .dly   (path_dly[p]),
            .out   (path_out[p])
        );
    end

    assign out_a = path_out[0];
    assign out_b = path_out[1];
endmodule

// File: rtl/dbg_deadband_chk.sv
// Checker for the dead-band generator, attached to every instance by bind.
// Assumes: same parameters as the checked instance.
module dbg_deadband_chk #(
    parameter int DLY_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             pwm_in,
    input logic [DLY_W-1:0] rise_dly,
    input logic [DLY_W-1:0] fall_dly,
    input logic             out_a,
    input logic             out_b
);
    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (!out_a && !out_b)); // R1

    AST_A_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !pwm_in) |=> !out_a); // R2

    AST_B_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pwm_in) |=> !out_b); // R3

    AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && enable && rise_dly == '0 && pwm_in && !$past(pwm_in)) |=> out_a); // R4

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a && out_b)); // R7

    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !enable) |=> (out_a == $past(pwm_in) && out_b == !$past(pwm_in))); // R8
endmodule

bind dbg_deadband dbg_deadband_chk #(.DLY_W(DLY_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .pwm_in   (pwm_in),
    .rise_dly (rise_dly),
    .fall_dly (fall_dly),
    .out_a    (out_a),
    .out_b    (out_b)
);

// File: tb/dbg_deadband_test.sv
module dbg_deadband_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       pwm_in = 1'b1;
    logic [9:0] rise_dly = 10'd20;
    logic [9:0] fall_dly = 10'd20;
    logic       out_a, out_b;

    int n_chk = 0;
    int n_err = 0;
    int n_overlap = 0;

    always #5 clk = ~clk;

    dbg_deadband uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_in(pwm_in),
        .rise_dly(rise_dly), .fall_dly(fall_dly), .out_a(out_a), .out_b(out_b)
    );

    typedef struct packed {
        int red;
        int fed;
        int hi;
        int lo;
    } vec_t;

    // rise delay, fall delay, high clocks, low clocks
    localparam vec_t VECS [8] = '{
        '{20, 20, 50, 40},  // typical setting
        '{0,  0,  5,  5},   // zero delay
        '{3,  7,  3, 12},   // pulse equal to rise delay
        '{3,  2,  4, 10},   // pulse one longer than rise delay
        '{1,  1,  2,  3},
        '{5,  9, 10,  6},   // low interval shorter than fall delay
        '{15, 4, 30,  8},
        '{2,  0,  6,  1}
    };

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock step: drive at negedge, sample after the following posedge.
    task automatic step(logic v);
        pwm_in = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    // R7: overlap monitor across the whole run
    always @(negedge clk) if (rst_n && out_a && out_b) n_overlap++;

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        int a_first, a_cnt, b_cnt, bad_a, bad_b;
        // R1: reset with input high
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_a in reset", out_a, 0);
        check("R1 out_b in reset", out_b, 0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5
        foreach (VECS[i]) begin
            rise_dly = 10'(VECS[i].red);
            fall_dly = 10'(VECS[i].fed);
            repeat (45) step(1'b0);
            bad_a = 0; bad_b = 0;
            for (int k = 0; k < VECS[i].hi + VECS[i].lo; k++) begin
                step(k < VECS[i].hi);
                if (out_a != (k >= VECS[i].red && k < VECS[i].hi)) bad_a++;
                if (out_b != (k >= VECS[i].hi + VECS[i].fed)) bad_b++;
            end
            check($sformatf("R2/R4/R5 out_a pattern vector %0d", i), bad_a, 0);
            check($sformatf("R3/R4/R5 out_b pattern vector %0d", i), bad_b, 0);
        end

        // R6: restart of the rise delay by a new edge
        rise_dly = 10'd5; fall_dly = 10'd3;
        repeat (10) step(1'b0);
        a_first = -1; a_cnt = 0;
        for (int k = 0; k < 15; k++) begin
            step(!(k == 3 || k == 4));
            if (out_a) begin a_cnt++; if (a_first < 0) a_first = k; end
        end
        check("R6 out_a first high after restart", a_first, 10);
        check("R6 out_a high count", a_cnt, 5);

        // R9: full-range delays
        rise_dly = 10'd1023; fall_dly = 10'd1023;
        repeat (1030) step(1'b0);
        a_first = -1; a_cnt = 0; b_cnt = 0;
        for (int k = 0; k < 1030; k++) begin
            step(1'b1);
            if (out_a) begin a_cnt++; if (a_first < 0) a_first = k; end
        end
        for (int k = 0; k < 1030; k++) begin
            step(1'b0);
            if (out_b) b_cnt++;
        end
        check("R9 out_a first high at 1023", a_first, 1023);
        check("R9 out_a high count", a_cnt, 7);
        check("R9 out_b high count", b_cnt, 7);

        // R8: bypass ignores the delays
        enable = 1'b0; rise_dly = 10'd20; fall_dly = 10'd20;
        bad_a = 0;
        for (int k = 0; k < 12; k++) begin
            logic v;
            v = ((k * 5) % 3) == 1;
            step(v);
            if (out_a != v || out_b != !v) bad_a++;
        end
        check("R8 bypass follows input", bad_a, 0);
        enable = 1'b1;

        // R1: reset mid-run clears state; fresh fall delay afterwards
        fall_dly = 10'd3;
        repeat (10) step(1'b0);
        check("R1 out_b high before reset", out_b, 1);
        rst_n = 1'b0;
        step(1'b0);
        check("R1 out_b low after reset edge", out_b, 0);
        check("R1 out_a low after reset edge", out_a, 0);
        rst_n = 1'b1;
        bad_b = 0;
        for (int k = 0; k < 6; k++) begin
            step(1'b0);
            if (out_b != (k >= 3)) bad_b++;
        end
        check("R1 out_b delay after release", bad_b, 0);

        check("R7 overlap cycles", n_overlap, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule